// File: doc/BRIEF.md
# Audio Playback Scheduler with Underrun Hold

This block paces the playback of audio samples toward a 12-bit DAC. A free-running divider makes one sample tick every `CLK_PER_SAMPLE` clocks; the default of 1000 gives 48 000 ticks per second from a 48 MHz clock. The same tick leaves the block as `conv_start`, so one timebase drives both the capture converter and playback.

Samples sit in an external sample store addressed by a pair of pointers. `rd_ptr` is the next sample to play and `end_ptr` is one past the last. Normally the receive path loads this pair when a packet of 64 signed s.15 samples has arrived. In loopback mode the pair comes from the capture side when one of its buffers completes.

On each tick, if `rd_ptr` differs from `end_ptr`, the block reads the sample at `rd_ptr` and advances the pointer. It converts the sample to an unsigned 12-bit code and pulses a DAC write request. If no sample remains, it issues nothing, so the DAC holds its last value, and it counts an underrun.

The sequencer has three states:
- `S_IDLE` waits for a tick. Transition *fetch*: `S_IDLE` to `S_WAIT_DATA` on a tick with a sample available. Transition *starve*: `S_IDLE` to `S_IDLE` on a tick with none, which counts an underrun.
- `S_WAIT_DATA` waits one cycle for the store's registered read data. Transition *capture*: always to `S_EMIT`, latching the converted code.
- `S_EMIT` raises `dac_wr` for one cycle. Transition *done*: back to `S_IDLE`.

Top module: `playback_sched`

## Requirements
- R1: `conv_start` is high for exactly one cycle every `CLK_PER_SAMPLE` cycles, and the sequencer is always in `S_IDLE` when it rises.
- R2: With `loopback_en` low, a cycle with `rx_load` high replaces both pointers with `rx_start` and `rx_end`.
- R3: On a tick with `rd_ptr != end_ptr`, the block does three things:
  - it raises `mem_rd_en` in the tick cycle, with `mem_rd_addr = rd_ptr`;
  - it raises `dac_wr` for one cycle exactly two cycles after the tick;
  - it advances `rd_ptr` by one, modulo 2^`ADDR_W`.
  Samples therefore play in address order and wrap past the top of the store.
- R4: On a tick with `rd_ptr == end_ptr`, there is no read and no `dac_wr`, and `dac_code` keeps its previous value.
- R5: `dac_code` equals the sample with bit 15 inverted, keeping bits 15..4. So 0x0000→0x800, 0x7FFF→0xFFF, 0x8000→0x000, 0xFFFF→0x7FF and 0x1234→0x923.
- R6: A load while samples remain discards the remaining samples at once. Playback continues from the new `rd_ptr`.
- R7: With `loopback_en` high, `cap_load`/`cap_start`/`cap_end` load the pointers and `rx_load` is ignored. With it low, `cap_load` is ignored.
- R8: `underrun_cnt` rises by one on each tick that finds no sample and saturates at its maximum value.
- R9: After reset, `dac_code` is 0x800, `dac_wr`, `mem_rd_en` and `underrun_cnt` are zero, and no sample is pending.
- R10: A load in the same cycle as a tick takes effect first. That tick plays the first sample of the new range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loopback_en | input | 1 | Selects capture buffers as the pointer source |
| rx_load | input | 1 | Receive side: new packet pointers valid |
| rx_start | input | ADDR_W | Receive side: first sample address |
| rx_end | input | ADDR_W | Receive side: one past last sample |
| cap_load | input | 1 | Capture side: completed buffer pointers valid |
| cap_start | input | ADDR_W | Capture side: first sample address |
| cap_end | input | ADDR_W | Capture side: one past last sample |
| mem_rd_en | output | 1 | Sample store read request |
| mem_rd_addr | output | ADDR_W | Sample store read address |
| mem_rd_data | input | 16 | Sample store data, valid one cycle after the request |
| conv_start | output | 1 | Sample tick, also starts a capture conversion |
| dac_wr | output | 1 | DAC write request |
| dac_code | output | 12 | Unsigned DAC code |
| underrun_cnt | output | UNDER_W | Saturating count of starved ticks |

## Verification
A wrong pointer becomes visible at the first tick after the fault. It shows up as a wrong sample order on `dac_code`, as a write the scoreboard did not expect, or as a missing write together with an extra underrun.

A sequencer stuck outside `S_IDLE` or a mistimed `S_EMIT` shows within one tick period, because every write is timed against its tick. A broken source select or a load that fails to replace the range appears at the next tick as a code from the wrong range.

// File: rtl/pb_pkg.sv
package pb_pkg;

    localparam int SAMPLE_W = 16;
    localparam int DAC_W    = 12;

    typedef enum logic [1:0] {
        S_IDLE      = 2'd0,
        S_WAIT_DATA = 2'd1,
        S_EMIT      = 2'd2
    } pb_state_e;

    // signed s.15 to offset-binary 12-bit code
    function automatic logic [DAC_W-1:0] s15_to_code(input logic [SAMPLE_W-1:0] s);
        return {~s[SAMPLE_W-1], s[SAMPLE_W-2 -: DAC_W-1]};
    endfunction

endpackage

// File: rtl/pb_tick_gen.sv
module pb_tick_gen #(
    parameter int CLK_PER_SAMPLE = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int TW = (CLK_PER_SAMPLE > 1) ? $clog2(CLK_PER_SAMPLE) : 1;
    localparam logic [TW-1:0] LAST = TW'(CLK_PER_SAMPLE - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + TW'(1);
    end

    assign tick = (cnt == LAST);

    // R1: a tick never lasts two cycles
    p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/pb_ptr_regs.sv
module pb_ptr_regs #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loopback_en,
    input  logic              rx_load,
    input  logic [ADDR_W-1:0] rx_start,
    input  logic [ADDR_W-1:0] rx_end,
    input  logic              cap_load,
    input  logic [ADDR_W-1:0] cap_start,
    input  logic [ADDR_W-1:0] cap_end,
    input  logic              adv,
    output logic              avail,
    output logic [ADDR_W-1:0] fetch_addr
);
    logic [ADDR_W-1:0] rd_ptr, end_ptr;
    logic              ld_go;
    logic [ADDR_W-1:0] ld_start, ld_end, eff_start, eff_end;

    // pointer source select
    always_comb begin
        if (loopback_en) begin
            ld_go    = cap_load;
            ld_start = cap_start;
            ld_end   = cap_end;
        end else begin
            ld_go    = rx_load;
            ld_start = rx_start;
            ld_end   = rx_end;
        end
    end

    // a load in the tick cycle is seen by that tick
    assign eff_start  = ld_go ? ld_start : rd_ptr;
    assign eff_end    = ld_go ? ld_end   : end_ptr;
    assign avail      = (eff_start != eff_end);
    assign fetch_addr = eff_start;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr  <= '0;
            end_ptr <= '0;
        end else if (adv) begin
            rd_ptr  <= eff_start + ADDR_W'(1);
            end_ptr <= eff_end;
        end else if (ld_go) begin
            rd_ptr  <= ld_start;
            end_ptr <= ld_end;
        end
    end

    // R3: each fetched sample moves the read pointer by one
    p_ptr_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ld_go) |=> (rd_ptr == $past(rd_ptr) + ADDR_W'(1)));

    // R6: a load discards what remained
    p_load_replace_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_go && !adv) |=> (rd_ptr == $past(ld_start) && end_ptr == $past(ld_end)));

    // R7: the unselected source cannot disturb the pointers
    p_source_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!loopback_en && cap_load && !rx_load && !adv) |=> ($stable(rd_ptr) && $stable(end_ptr)));

endmodule

// File: rtl/pb_seq_fsm.sv
module pb_seq_fsm
    import pb_pkg::*;
#(
    parameter int UNDER_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                avail,
    input  logic [SAMPLE_W-1:0] rd_data,
    output logic                adv,
    output logic                rd_en,
    output logic                dac_wr,
    output logic [DAC_W-1:0]    dac_code,
    output logic [UNDER_W-1:0]  underrun_cnt
);
    pb_state_e state, state_nx;
    logic      starve;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:      if (tick && avail) state_nx = S_WAIT_DATA;
            S_WAIT_DATA: state_nx = S_EMIT;
            S_EMIT:      state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        adv    = 1'b0;
        starve = 1'b0;
        dac_wr = 1'b0;
        unique case (state)
            S_IDLE: begin
                adv    = tick && avail;
                starve = tick && !avail;
            end
            S_WAIT_DATA: ;
            S_EMIT:  dac_wr = 1'b1;
            default: ;
        endcase
    end

    assign rd_en = adv;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_code     <= {1'b1, {(DAC_W-1){1'b0}}};
            underrun_cnt <= '0;
        end else begin
            if (state == S_WAIT_DATA) dac_code <= s15_to_code(rd_data);
            if (starve && underrun_cnt != {UNDER_W{1'b1}})
                underrun_cnt <= underrun_cnt + UNDER_W'(1);
        end
    end

    // R1: ticks only arrive while the sequencer is idle
    p_tick_in_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (state == S_IDLE));

    // R3: a read is followed two cycles later by a write
    p_write_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> ##2 dac_wr);

    // R4: a starved tick produces no write
    p_no_write_starved_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !avail) |-> ##2 !dac_wr);

    // R8: the counter only ever steps by one
    p_underrun_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(underrun_cnt) |-> (underrun_cnt == $past(underrun_cnt) + UNDER_W'(1)));

endmodule

// File: rtl/playback_sched.sv
module playback_sched #(
    parameter int CLK_PER_SAMPLE = 1000,
    parameter int ADDR_W         = 8,
    parameter int UNDER_W        = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               loopback_en,
    input  logic               rx_load,
    input  logic [ADDR_W-1:0]  rx_start,
    input  logic [ADDR_W-1:0]  rx_end,
    input  logic               cap_load,
    input  logic [ADDR_W-1:0]  cap_start,
    input  logic [ADDR_W-1:0]  cap_end,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic [15:0]        mem_rd_data,
    output logic               conv_start,
    output logic               dac_wr,
    output logic [11:0]        dac_code,
    output logic [UNDER_W-1:0] underrun_cnt
);
    if (CLK_PER_SAMPLE < 4) begin : g_bad_rate
        $error("CLK_PER_SAMPLE must be at least 4");
    end

    logic tick, avail, adv;

    pb_tick_gen #(.CLK_PER_SAMPLE(CLK_PER_SAMPLE)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    pb_ptr_regs #(.ADDR_W(ADDR_W)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .loopback_en (loopback_en),
        .rx_load     (rx_load),
        .rx_start    (rx_start),
        .rx_end      (rx_end),
        .cap_load    (cap_load),
        .cap_start   (cap_start),
        .cap_end     (cap_end),
        .adv         (adv),
        .avail       (avail),
        .fetch_addr  (mem_rd_addr)
    );

    pb_seq_fsm #(.UNDER_W(UNDER_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .avail        (avail),
        .rd_data      (mem_rd_data),
        .adv          (adv),
        .rd_en        (mem_rd_en),
        .dac_wr       (dac_wr),
        .dac_code     (dac_code),
        .underrun_cnt (underrun_cnt)
    );

    assign conv_start = tick;

endmodule

// File: tb/playback_sched_test.sv
module playback_sched_test;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV       = 16;
    localparam int AW         = 8;
    localparam int UW         = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          loopback_en = 1'b0;
    logic          rx_load = 1'b0, cap_load = 1'b0;
    logic [AW-1:0] rx_start = '0, rx_end = '0, cap_start = '0, cap_end = '0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [15:0]   mem_rd_data;
    logic          conv_start, dac_wr;
    logic [11:0]   dac_code;
    logic [UW-1:0] underrun_cnt;

    int checks = 0, fails = 0;
    logic [15:0] mem [256];
    logic [11:0] exp_q [$];
    int  rem = 0;
    int  exp_under = 0;
    int  since = 0;
    bit  seen_tick = 0;
    string tag = "R3";

    always #(CLK_PERIOD/2) clk = ~clk;

    playback_sched #(.CLK_PER_SAMPLE(TDIV), .ADDR_W(AW), .UNDER_W(UW)) uut (
        .clk(clk), .rst_n(rst_n), .loopback_en(loopback_en),
        .rx_load(rx_load), .rx_start(rx_start), .rx_end(rx_end),
        .cap_load(cap_load), .cap_start(cap_start), .cap_end(cap_end),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .conv_start(conv_start), .dac_wr(dac_wr), .dac_code(dac_code),
        .underrun_cnt(underrun_cnt)
    );

    // sample store model with one cycle read latency
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

    function automatic logic [11:0] to_code(input logic [15:0] v);
        return {~v[15], v[14:4]};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: tick spacing, write timing, scoreboard pop
    always @(negedge clk) begin
        if (rst_n) begin
            since++;
            if (conv_start) begin
                if (seen_tick) check("R1 tick spacing", since, TDIV);
                seen_tick = 1;
                since = 0;
                if (rem > 0) rem--;
                else if (exp_under < (1 << UW) - 1) exp_under++;
            end
            if (dac_wr) begin
                check("R3 write delay after tick", since, 2);
                if (exp_q.size() == 0) check("R4 unexpected write", 1, 0);
                else check({tag, " dac code"}, dac_code, exp_q.pop_front());
            end
        end
    end

    task automatic wait_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            while (!conv_start) @(negedge clk);
        end
    endtask

    task automatic push_range(input logic [AW-1:0] s, input logic [AW-1:0] e);
        exp_q.delete();
        rem = int'(AW'(e - s));
        for (logic [AW-1:0] a = s; a != e; a++) exp_q.push_back(to_code(mem[a]));
    endtask

    task automatic drive(input bit cap, input logic [AW-1:0] s, input logic [AW-1:0] e);
        if (cap) begin cap_load = 1; cap_start = s; cap_end = e; end
        else     begin rx_load = 1;  rx_start = s;  rx_end = e;  end
    endtask

    // load away from any tick; counted says whether the load is selected
    task automatic load(input bit cap, input logic [AW-1:0] s, input logic [AW-1:0] e,
                        input bit counted, input string t);
        wait_ticks(1);
        repeat (4) @(posedge clk);
        #1;
        drive(cap, s, e);
        if (counted) begin tag = t; push_range(s, e); end
        @(posedge clk); #1;
        rx_load = 0; cap_load = 0;
    endtask

    task automatic check_under(input string req);
        repeat (3) @(negedge clk);
        check(req, underrun_cnt, exp_under);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0313) ^ 16'h5A5A;
        mem[200] = 16'h0000; mem[201] = 16'h7FFF; mem[202] = 16'h8000;
        mem[203] = 16'hFFFF; mem[204] = 16'h1234;

        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check("R9 reset dac_code", dac_code, 12'h800);
        check("R9 reset dac_wr", dac_wr, 0);
        check("R9 reset mem_rd_en", mem_rd_en, 0);
        check("R9 reset underrun", underrun_cnt, 0);

        // R4/R8: starved ticks after reset
        wait_ticks(2);
        check_under("R8 underrun after starved ticks");
        check("R4 code held at midscale", dac_code, 12'h800);

        // R2/R3: one packet of 8 then starvation
        load(0, 8'd0, 8'd8, 1, "R2");
        wait_ticks(10);
        check_under("R8 underrun after drain");
        check("R4 code held after drain", dac_code, to_code(mem[7]));
        check("R3 all samples played", exp_q.size(), 0);

        // R6: replace mid-playback, new range holds R5 corners
        load(0, 8'd20, 8'd40, 1, "R6");
        wait_ticks(3);
        load(0, 8'd200, 8'd205, 1, "R5");
        wait_ticks(7);
        check("R6 replaced range done", exp_q.size(), 0);
        check("R5 last corner 0x1234", dac_code, 12'h923);

        // R10: load coinciding with tick
        wait_ticks(1);
        repeat (TDIV) @(posedge clk);
        #1 drive(0, 8'd50, 8'd54); tag = "R10"; push_range(8'd50, 8'd54);
        @(posedge clk); #1 rx_load = 0;
        wait_ticks(6);
        check("R10 coincident range done", exp_q.size(), 0);

        // R7: loopback source select
        loopback_en = 1;
        load(0, 8'd60, 8'd70, 0, "R7");
        wait_ticks(2);
        check_under("R7 rx load ignored in loopback");
        load(1, 8'd100, 8'd104, 1, "R7");
        wait_ticks(5);
        check("R7 capture range played", exp_q.size(), 0);
        loopback_en = 0;
        load(1, 8'd110, 8'd120, 0, "R7");
        wait_ticks(2);
        check_under("R7 cap load ignored without loopback");

        // R3: wrap past the top of the store
        load(0, 8'd250, 8'd4, 1, "R3 wrap");
        wait_ticks(12);
        check("R3 wrap range done", exp_q.size(), 0);

        // R8: saturation
        wait_ticks(20);
        check_under("R8 saturated underrun");
        check("R8 saturation value", underrun_cnt, (1 << UW) - 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule